// File: doc/BRIEF.md
# Dual 16-bit Match Timer

This peripheral holds two independent 16-bit counting subtimers behind one register window, plus six shared compare values. Each subtimer has a count value, a prescale divider and a small control word. The control word starts or halts the subtimer, picks up or down counting, and picks the end condition: count to zero, stop on one of the six compare values, or run forever with wraparound.

Only the first subtimer raises interrupts. When it stops on compare value n, it sets pending bit n in a second, separate register window. That window holds the pending bits, which software clears by writing ones, and a per-bit enable mask. A single level interrupt line is high while any pending bit is enabled. The second subtimer is normally left free-running as a readable time base.

Both windows use a simple single-cycle bus. A write takes effect on the clock edge where the write enable is high, and read data is combinational from the address.

Top module: `dual_match_timer`

## Requirements
- R1: After a synchronous active-low reset, both control words read 0x10 (halted). Every count, divider, compare, pending and mask value reads 0, and `irq` is low.
- R2: Timer window byte offsets: subtimer A count 0x00, divider 0x04, control 0x08; subtimer B count 0x0C, divider 0x10, control 0x14; compare value n at 0x18+4n for n = 0..5. Each offset reads back what was last written to it.
- R3: With divider value D, a running subtimer steps once every D+1 clocks. The first step comes D+1 clock edges after the edge that writes the run command or a new count.
- R4: Control bit 3 selects direction: 1 counts up, 0 counts down, modulo 2^16.
- R5: Control bits 2:0 equal to 0 stop the subtimer on the step that reaches zero. The stop sets control bit 4 and raises no pending bit.
- R6: Control bits 2:0 equal to m (1..6) stop the subtimer on the step whose new count equals compare value m-1. The stop sets control bit 4, and for subtimer A it also sets pending bit m-1.
- R7: Control bits 2:0 equal to 7 keep counting through the wrap, and the control word keeps bit 4 clear.
- R8: Subtimer B never sets a pending bit, even when it stops on a compare value.
- R9: Interrupt window offset 0x00 reads the 6 pending bits, and a write there clears exactly the bits written as 1. Offset 0x04 holds the enable mask. If a pending bit is set and cleared on the same edge, it ends set.
- R10: `irq` is high exactly while some pending bit is set and has its mask bit set.
- R11: A write to a count offset loads that value even while the subtimer runs, and counting continues from the new value.
- R12: Reads of unused offsets in either window return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_we | input | 1 | Timer window write enable |
| tmr_addr | input | 6 | Timer window byte offset |
| tmr_wdata | input | 16 | Timer window write data |
| tmr_rdata | output | 16 | Timer window read data |
| irq_we | input | 1 | Interrupt window write enable |
| irq_addr | input | 4 | Interrupt window byte offset |
| irq_wdata | input | 6 | Interrupt window write data |
| irq_rdata | output | 6 | Interrupt window read data |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest case to reach from the ports is a pending bit being set and acknowledged on the same edge. This only happens when a bus write lands exactly on the clock edge of subtimer A's terminal step. The stimulus therefore loads a small count with divider 0 and issues the run command. It then counts edges from that command so that an acknowledge of the same bit lands on the terminal edge. The pending bit must survive. Prescaler timing is checked the same way: the count is sampled one edge before and on the edge where the first step is due.

// File: rtl/dmt_pkg.sv
`timescale 1ns/100ps
// Shared constants for the dual match timer: control word layout,
// terminal modes and register window offsets.
package dmt_pkg;
    localparam int NUM_SUB    = 2;   // subtimers in the window
    localparam int NUM_MATCH  = 6;   // shared compare values
    localparam int MODE_W     = 3;   // terminal mode field width
    localparam int CTL_W      = 5;   // control word width
    localparam int CTL_HALT   = 4;   // 1 = halted
    localparam int CTL_UP     = 3;   // 1 = count up
    localparam logic [MODE_W-1:0] MODE_ZERO    = 3'd0;
    localparam logic [MODE_W-1:0] MODE_FOREVER = 3'd7;
    localparam logic [CTL_W-1:0]  CTL_RESET    = 5'h10;
    // timer window byte offsets
    localparam int OFF_VAL    = 0;
    localparam int OFF_DIV    = 4;
    localparam int OFF_CTL    = 8;
    localparam int SUB_STRIDE = 12;
    localparam int MATCH_BASE = 24;
    // interrupt window byte offsets
    localparam int IRQ_PEND   = 0;
    localparam int IRQ_MASK   = 4;
endpackage

// File: rtl/dmt_subtimer.sv
`timescale 1ns/100ps
// One subtimer: count value, prescaler and control word.
// Assumes the bus write strobes are already decoded for this subtimer.
// hit_o pulses on the step that meets the selected end condition.
// The halt bit is set on that same edge.
module dmt_subtimer
    import dmt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_val_i,
    input  logic                            wr_div_i,
    input  logic                            wr_ctl_i,
    input  logic [CNT_W-1:0]                wdata_i,
    input  logic [NUM_MATCH-1:0][CNT_W-1:0] match_i,
    output logic [CNT_W-1:0]                cnt_o,
    output logic [CNT_W-1:0]                div_o,
    output logic [CTL_W-1:0]                ctl_o,
    output logic                            hit_o
);
    logic [CNT_W-1:0]  pre_q;
    logic [CNT_W-1:0]  next_cnt;
    logic [CNT_W-1:0]  target;
    logic              term_en;
    logic              running;
    logic              tick;
    logic [MODE_W-1:0] mode;

    assign running  = !ctl_o[CTL_HALT];
    assign mode     = ctl_o[MODE_W-1:0];
    assign tick     = running && (pre_q == div_o);
    assign next_cnt = ctl_o[CTL_UP] ? cnt_o + 1'b1 : cnt_o - 1'b1;
    assign hit_o    = tick && term_en && (next_cnt == target);

    // Select the end-condition compare value from the mode field.
    always_comb begin
        target  = '0;
        term_en = (mode == MODE_ZERO);
        for (int i = 0; i < NUM_MATCH; i++) begin
            if (mode == MODE_W'(i + 1)) begin
                target  = match_i[i];
                term_en = 1'b1;
            end
        end
    end

    // Prescaler: restart on any count/control write, or while halted.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    pre_q <= '0;
        else if (wr_val_i || wr_ctl_i || !running || tick) pre_q <= '0;
        else                                           pre_q <= pre_q + 1'b1;
    end

    // Count value: a bus write has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_o <= '0;
        else if (wr_val_i) cnt_o <= wdata_i;
        else if (tick)     cnt_o <= next_cnt;
    end

    // Divider register.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_o <= '0;
        else if (wr_div_i) div_o <= wdata_i;
    end

    // Control word: a bus write wins; otherwise the terminal step halts.
    always_ff @(posedge clk) begin
        if (!rst_n)        ctl_o <= CTL_RESET;
        else if (wr_ctl_i) ctl_o <= wdata_i[CTL_W-1:0];
        else if (hit_o)    ctl_o[CTL_HALT] <= 1'b1;
    end
endmodule

// File: rtl/dmt_irq_ctrl.sv
`timescale 1ns/100ps
// Interrupt window: pending bits with write-one-to-clear and an enable mask.
// Assumes set_i is a one-cycle pulse vector. A set beats a clear of the
// same bit on the same edge.
module dmt_irq_ctrl
    import dmt_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [AW-1:0]        addr_i,
    input  logic [NUM_MATCH-1:0] wdata_i,
    input  logic [NUM_MATCH-1:0] set_i,
    output logic [NUM_MATCH-1:0] rdata_o,
    output logic [NUM_MATCH-1:0] pend_o,
    output logic [NUM_MATCH-1:0] mask_o,
    output logic                 irq_o
);
    logic [NUM_MATCH-1:0] clr;

    assign clr   = (we_i && int'(addr_i) == IRQ_PEND) ? wdata_i : '0;
    assign irq_o = |(pend_o & mask_o);

    // Pending bits: clear the written ones, then merge new sets.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= '0;
        else        pend_o <= (pend_o & ~clr) | set_i;
    end

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 mask_o <= '0;
        else if (we_i && int'(addr_i) == IRQ_MASK)  mask_o <= wdata_i;
    end

    // Read mux; unused offsets read zero.
    always_comb begin
        rdata_o = '0;
        if (int'(addr_i) == IRQ_PEND) rdata_o = pend_o;
        if (int'(addr_i) == IRQ_MASK) rdata_o = mask_o;
    end
endmodule

// File: rtl/dual_match_timer.sv
`timescale 1ns/100ps
// Dual match timer top: decodes the timer window and holds the shared
// compare values. Subtimer A drives the pending bits; subtimer B does not.
// Assumes single-cycle bus writes and combinational reads.
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int TMR_AW  = 6,
    parameter int IRQ_AW  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tmr_we,
    input  logic [TMR_AW-1:0]    tmr_addr,
    input  logic [CNT_W-1:0]     tmr_wdata,
    output logic [CNT_W-1:0]     tmr_rdata,
    input  logic                 irq_we,
    input  logic [IRQ_AW-1:0]    irq_addr,
    input  logic [NUM_MATCH-1:0] irq_wdata,
    output logic [NUM_MATCH-1:0] irq_rdata,
    output logic                 irq
);
    logic [NUM_MATCH-1:0][CNT_W-1:0] match_q;
    logic [CNT_W-1:0]                cnt_v [NUM_SUB];
    logic [CNT_W-1:0]                div_v [NUM_SUB];
    logic [CTL_W-1:0]                ctl_v [NUM_SUB];
    logic [NUM_SUB-1:0]              hit_v;
    logic [NUM_MATCH-1:0]            pend_set;
    logic [NUM_MATCH-1:0]            pend_q;
    logic [NUM_MATCH-1:0]            mask_q;

    for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
        localparam int BASE = s * SUB_STRIDE;
        dmt_subtimer #(.CNT_W(CNT_W)) u_sub (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_val_i (tmr_we && int'(tmr_addr) == BASE + OFF_VAL),
            .wr_div_i (tmr_we && int'(tmr_addr) == BASE + OFF_DIV),
            .wr_ctl_i (tmr_we && int'(tmr_addr) == BASE + OFF_CTL),
            .wdata_i  (tmr_wdata),
            .match_i  (match_q),
            .cnt_o    (cnt_v[s]),
            .div_o    (div_v[s]),
            .ctl_o    (ctl_v[s]),
            .hit_o    (hit_v[s])
        );
    end

    for (genvar m = 0; m < NUM_MATCH; m++) begin : g_match
        // Compare value register m.
        always_ff @(posedge clk) begin
            if (!rst_n) match_q[m] <= '0;
            else if (tmr_we && int'(tmr_addr) == MATCH_BASE + 4 * m)
                match_q[m] <= tmr_wdata;
        end
        // Subtimer A stopping in mode m+1 raises pending bit m.
        assign pend_set[m] = hit_v[0] && (ctl_v[0][MODE_W-1:0] == MODE_W'(m + 1));
    end

    // Timer window read mux; unused offsets read zero.
    always_comb begin
        tmr_rdata = '0;
        for (int s = 0; s < NUM_SUB; s++) begin
            if (int'(tmr_addr) == s * SUB_STRIDE + OFF_VAL) tmr_rdata = cnt_v[s];
            if (int'(tmr_addr) == s * SUB_STRIDE + OFF_DIV) tmr_rdata = div_v[s];
            if (int'(tmr_addr) == s * SUB_STRIDE + OFF_CTL) tmr_rdata = CNT_W'(ctl_v[s]);
        end
        for (int m = 0; m < NUM_MATCH; m++) begin
            if (int'(tmr_addr) == MATCH_BASE + 4 * m) tmr_rdata = match_q[m];
        end
    end

    dmt_irq_ctrl #(.AW(IRQ_AW)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (irq_we),
        .addr_i  (irq_addr),
        .wdata_i (irq_wdata),
        .set_i   (pend_set),
        .rdata_o (irq_rdata),
        .pend_o  (pend_q),
        .mask_o  (mask_q),
        .irq_o   (irq)
    );
endmodule

// File: rtl/dmt_checker.sv
`timescale 1ns/100ps
// Protocol checker for dual_match_timer, attached with bind below.
// Observes subtimer outputs, pending/mask state and the bus strobes.
module dmt_checker
    import dmt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int IRQ_AW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tmr_we,
    input logic                 irq_we,
    input logic [IRQ_AW-1:0]    irq_addr,
    input logic [NUM_MATCH-1:0] irq_wdata,
    input logic                 irq,
    input logic [CNT_W-1:0]     cnt0,
    input logic [CTL_W-1:0]     ctl0,
    input logic [CTL_W-1:0]     ctl1,
    input logic                 hit0,
    input logic                 hit1,
    input logic [NUM_MATCH-1:0] pend,
    input logic [NUM_MATCH-1:0] mask
);
    logic [NUM_MATCH-1:0] want;

    // Pending bit that subtimer A's current mode would raise.
    always_comb begin
        for (int i = 0; i < NUM_MATCH; i++)
            want[i] = (ctl0[MODE_W-1:0] == MODE_W'(i + 1));
    end

    // R1: leaving reset, both subtimers halted and no interrupt.
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctl0[CTL_HALT] && ctl1[CTL_HALT] && !irq && pend == '0));

    // R5: a halted subtimer A holds its count unless the bus writes.
    assert_halt_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl0[CTL_HALT] && !tmr_we) |=> $stable(cnt0));

    // R6: a terminal step halts subtimer A.
    assert_hit_halts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && !tmr_we) |=> ctl0[CTL_HALT]);

    // R6: a compare stop on subtimer A raises its pending bit.
    assert_hit_pends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit0 && |want) |=> |(pend & $past(want)));

    // R8: subtimer B alone never raises pending bits.
    assert_sub_b_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit1 && !hit0) |=> ((pend & ~$past(pend)) == '0));

    // R9: acknowledged bits clear when no set collides.
    assert_ack_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_we && int'(irq_addr) == IRQ_PEND && !hit0) |=> ((pend & $past(irq_wdata)) == '0));

    // R10: no interrupt while the mask is empty.
    assert_mask_gates_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

bind dual_match_timer dmt_checker #(.CNT_W(CNT_W), .IRQ_AW(IRQ_AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tmr_we    (tmr_we),
    .irq_we    (irq_we),
    .irq_addr  (irq_addr),
    .irq_wdata (irq_wdata),
    .irq       (irq),
    .cnt0      (cnt_v[0]),
    .ctl0      (ctl_v[0]),
    .ctl1      (ctl_v[1]),
    .hit0      (hit_v[0]),
    .hit1      (hit_v[1]),
    .pend      (pend_q),
    .mask      (mask_q)
);

// File: tb/dual_match_timer_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: driver tasks queue expected reads, a monitor compares.
module dual_match_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tmr_we = 1'b0;
    logic [5:0]  tmr_addr = '0;
    logic [15:0] tmr_wdata = '0;
    logic [15:0] tmr_rdata;
    logic        irq_we = 1'b0;
    logic [3:0]  irq_addr = '0;
    logic [5:0]  irq_wdata = '0;
    logic [5:0]  irq_rdata;
    logic        irq;

    typedef struct {
        int    kind;   // 0 timer read, 1 irq window read, 2 irq pin
        int    exp;
        string tag;
    } item_t;

    item_t q[$];
    event  ev_sample;
    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;

    dual_match_timer u_dut (
        .clk(clk), .rst_n(rst_n),
        .tmr_we(tmr_we), .tmr_addr(tmr_addr), .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata),
        .irq_we(irq_we), .irq_addr(irq_addr), .irq_wdata(irq_wdata), .irq_rdata(irq_rdata),
        .irq(irq)
    );

    always #5 clk = ~clk;

    // Monitor: pop the expected item and compare with the live output.
    initial begin
        forever begin
            @(ev_sample);
            while (q.size() > 0) begin
                item_t it;
                int act;
                it = q.pop_front();
                act = (it.kind == 0) ? int'(tmr_rdata) :
                      (it.kind == 1) ? int'(irq_rdata) : int'(irq);
                checks++;
                if (act != it.exp) begin
                    errors++;
                    $display("FAIL %s actual 0x%0h expected 0x%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    // Called in the low phase; the write lands on the next rising edge.
    task automatic twr(input int a, input int d);
        tmr_addr = 6'(a); tmr_wdata = 16'(d); tmr_we = 1'b1;
        @(negedge clk);
        tmr_we = 1'b0;
    endtask

    task automatic iwr(input int a, input int d);
        irq_addr = 4'(a); irq_wdata = 6'(d); irq_we = 1'b1;
        @(negedge clk);
        irq_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push(input int kind, input int exp, input string tag);
        item_t it;
        it.kind = kind; it.exp = exp; it.tag = tag;
        #0.2;
        q.push_back(it);
        -> ev_sample;
        #0.2;
    endtask

    task automatic tchk(input int a, input int exp, input string tag);
        tmr_addr = 6'(a);
        push(0, exp, tag);
    endtask

    task automatic ichk(input int a, input int exp, input string tag);
        irq_addr = 4'(a);
        push(1, exp, tag);
    endtask

    task automatic pchk(input int exp, input string tag);
        push(2, exp, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        tchk(8'h00, 0,     "R1 subA count");
        tchk(8'h08, 'h10,  "R1 subA control halted");
        tchk(8'h14, 'h10,  "R1 subB control halted");
        tchk(8'h10, 0,     "R1 subB divider");
        tchk(8'h2C, 0,     "R1 compare 5");
        ichk(0, 0,         "R1 pending");
        ichk(4, 0,         "R1 mask");
        pchk(0,            "R1 irq low");

        // R2: address map read-back
        for (int n = 0; n < 6; n++) twr(8'h18 + 4 * n, 'h1110 + n);
        twr(8'h10, 'h0055);
        twr(8'h00, 'hABCD);
        for (int n = 0; n < 6; n++) tchk(8'h18 + 4 * n, 'h1110 + n, "R2 compare readback");
        tchk(8'h10, 'h0055, "R2 subB divider");
        tchk(8'h00, 'hABCD, "R2 subA count");
        tchk(8'h0C, 0,      "R2 subB count untouched");

        // R12: unused offsets
        twr(8'h30, 'h7777);
        tchk(8'h30, 0, "R12 unused timer offset");
        tchk(8'h3C, 0, "R12 unused timer offset high");
        ichk(8, 0,     "R12 unused irq offset");

        // R6/R4/R3/R10: subA down-count to compare 0
        twr(8'h18, 2);
        twr(8'h04, 0);
        twr(8'h00, 5);
        twr(8'h08, 'h01);
        tchk(8'h00, 5, "R3 no step on run edge");
        idle(1); tchk(8'h00, 4, "R4 down step");
        idle(1); tchk(8'h00, 3, "R4 down step 2");
        idle(1);
        tchk(8'h00, 2,    "R6 stopped at compare 0");
        tchk(8'h08, 'h11, "R6 halt bit set");
        ichk(0, 'h01,     "R6 pending bit 0");
        pchk(0,           "R10 masked irq low");
        idle(2); tchk(8'h00, 2, "R6 holds after stop");
        iwr(4, 'h01);
        pchk(1,           "R10 irq high when enabled");
        iwr(0, 'h02);
        ichk(0, 'h01,     "R9 ack of other bit ignored");
        pchk(1,           "R10 irq stays high");
        iwr(0, 'h01);
        ichk(0, 0,        "R9 ack clears bit");
        pchk(0,           "R10 irq low after ack");

        // R3/R7: subB divider 2, up forever across wrap
        twr(8'h10, 2);
        twr(8'h0C, 'hFFFE);
        twr(8'h14, 'h0F);
        tchk(8'h0C, 'hFFFE, "R3 start value");
        idle(2); tchk(8'h0C, 'hFFFE, "R3 no step before D+1");
        idle(1); tchk(8'h0C, 'hFFFF, "R3 step at D+1");
        idle(3); tchk(8'h0C, 0,      "R7 wrap to zero");
        tchk(8'h14, 'h0F,            "R7 still running");
        idle(3); tchk(8'h0C, 1,      "R7 counts past wrap");

        // R11: load while running
        twr(8'h0C, 'h1234);
        tchk(8'h0C, 'h1234, "R11 live load");
        idle(3); tchk(8'h0C, 'h1235, "R11 continues from load");
        twr(8'h14, 'h10);

        // R8: subB stops on compare 0 without pending
        twr(8'h10, 0);
        twr(8'h0C, 4);
        twr(8'h14, 'h01);
        idle(2);
        tchk(8'h0C, 2,    "R8 subB stopped at compare");
        tchk(8'h14, 'h11, "R8 subB halted");
        ichk(0, 0,        "R8 no pending from subB");
        pchk(0,           "R8 irq low");

        // R5: subA count to zero
        twr(8'h00, 3);
        twr(8'h08, 'h00);
        idle(3);
        tchk(8'h00, 0,    "R5 reached zero");
        tchk(8'h08, 'h10, "R5 halted at zero");
        ichk(0, 0,        "R5 no pending");

        // R4/R6: up count to compare 5
        twr(8'h2C, 'h0103);
        twr(8'h00, 'h0100);
        iwr(4, 'h20);
        twr(8'h08, 'h0E);
        tchk(8'h00, 'h0100, "R4 up start");
        idle(3);
        tchk(8'h00, 'h0103, "R4 up to compare 5");
        tchk(8'h08, 'h1E,   "R6 halted mode 6");
        ichk(0, 'h20,       "R6 pending bit 5");
        pchk(1,             "R10 irq from bit 5");
        iwr(0, 'h20);
        ichk(0, 0,          "R9 bit 5 cleared");
        pchk(0,             "R10 irq low");

        // R9: set and ack collide on the same edge
        twr(8'h18, 0);
        iwr(4, 'h01);
        twr(8'h00, 2);
        twr(8'h08, 'h01);
        idle(1);
        iwr(0, 'h01);
        ichk(0, 'h01, "R9 set beats ack");
        pchk(1,       "R9 irq after collision");
        iwr(0, 'h01);
        ichk(0, 0,    "R9 later ack clears");

        idle(1);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard actual %0d left expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule